// File: doc/BRIEF.md
# Descriptor-Chain Stream-to-Memory DMA Engine

This engine takes a byte stream from a client and writes it into memory buffers. The buffers are described by a linked chain of four-word data descriptors. Bytes arrive one per handshake on a valid/ready port, and each byte may carry an end-of-packet mark. The engine packs the bytes into bus words and writes them through a word-wide memory master. Any word that is only partly filled is written with byte enables.

A descriptor is retired in one of two ways: its buffer fills, or the client ends a packet inside it. On retirement the engine writes two words back into the descriptor. The first is the address where writing actually stopped. The second is the flags word, with a packet-ended marker added when the descriptor was closed by end-of-packet. Retirement also sets raw interrupt sources. The engine then moves to the descriptor named by the link word. If the retired descriptor is marked last-in-chain, the engine instead sets a disable bit in the context word and halts. A start pulse launches the engine at a new chain head.

Descriptor layout, as word offsets from the descriptor address: 0 = link to the next descriptor, 1 = buffer start address, 2 = flags, 3 = buffer end address (exclusive). In the flags word, bit 0 marks last-in-chain, bit 4 requests an interrupt, and bit 11 is the packet-ended marker written back by the engine.

Top module: `dma_in_engine`

## Requirements
- R1: Accepted bytes are stored at consecutive byte addresses, beginning at the descriptor's buffer start. No byte is ever stored at or beyond the buffer end address.
- R2: A descriptor retires as soon as its write position equals its end address. A descriptor whose start equals its end retires without accepting any byte.
- R3: A byte carrying end-of-packet retires the current descriptor immediately after that byte, even if buffer space remains.
- R4: On retirement, word 3 of the descriptor is overwritten with the final write position (start address plus the number of bytes stored).
- R5: On retirement, word 2 is written back with every original flag bit preserved. Bit 11 is set if and only if the descriptor was closed by end-of-packet.
- R6: Raw interrupt sources (irq_raw): retiring a descriptor whose flag bit 4 is set sets bits 0 and 1; retiring by end-of-packet sets bit 3; bit 2 is never set. A set bit stays set until a 1 is presented on the matching intr_ack bit.
- R7: irq is high exactly when some bit of irq_raw is set and is also set in intr_mask.
- R8: After a descriptor with flag bit 0 retires, the engine writes only byte 1 of the context word (at ctx_addr), setting it to 0x80. It then raises halted and holds in_ready low. Offered bytes are refused and memory is left unchanged until the next start pulse.
- R9: After a descriptor without flag bit 0 retires, the engine fetches the descriptor at the address in word 0. The next byte lands at that descriptor's buffer start.
- R10: Every memory write carries a non-empty byte enable. Bytes outside the region being written (descriptor fields, buffers, context) keep their contents.
- R11: A memory request keeps its address, data and enables unchanged until mem_ack. in_ready is never high while a descriptor fetch or writeback is pending.
- R12: After reset: in_ready, mem_req, irq_raw, irq and halted are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, honoured when idle or halted |
| start_desc | input | AW | Address of the first descriptor |
| ctx_addr | input | AW | Address of the context word that receives the disable bit |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_eop | input | 1 | Stream byte is the last of its packet |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | DW | Write data |
| mem_be | output | DW/8 | Byte enables for writes |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | DW | Read data |
| intr_mask | input | 4 | Interrupt mask |
| intr_ack | input | 4 | Clears the matching raw interrupt bits |
| irq_raw | output | 4 | Raw interrupt sources |
| irq | output | 1 | Masked interrupt line |
| halted | output | 1 | Chain ended; input refused |

## Verification
The hardest state to reach from the ports is a single descriptor retirement where several things coincide: an end-of-packet that also fills the buffer exactly, a buffer start and end that are not word aligned, and empty descriptors chained between full ones. The bench reaches this with directed chains and with random chains of zero to forty byte buffers at random alignments. Packet ends are placed at random, and memory acknowledges arrive at random, so retirements land on every byte lane and on every descriptor position in the chain.

// File: rtl/dma_in_pkg.sv
package dma_in_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RUN,
    ST_FLUSH,
    ST_WB_END,
    ST_WB_FLAGS,
    ST_WB_CTX,
    ST_HALT
  } eng_state_e;

  // descriptor word indices
  localparam int W_LINK  = 0;
  localparam int W_START = 1;
  localparam int W_FLAGS = 2;
  localparam int W_END   = 3;

  // flag bit positions in descriptor word 2
  localparam int FLAG_LAST    = 0;
  localparam int FLAG_IRQ     = 4;
  localparam int FLAG_PKT_END = 11;

  // context word disable bit
  localparam int CTX_OFF_BIT = 15;

  // raw interrupt layout
  localparam int RAW_W      = 4;
  localparam int RAW_DONE_A = 0;
  localparam int RAW_DONE_B = 1;
  localparam int RAW_PKT    = 3;

endpackage

// File: rtl/dma_in_packer.sv
module dma_in_packer #(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [LW-1:0] lane,
  input  logic [7:0]    din,
  input  logic          clr,
  output logic [DW-1:0] word,
  output logic [NB-1:0] be
);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] lane_byte;
    logic       lane_en;
    logic       hit;

    assign hit = take && (lane == LW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_byte <= '0;
        lane_en   <= 1'b0;
      end else if (clr) begin
        lane_en <= 1'b0;
      end else if (hit) begin
        lane_byte <= din;
        lane_en   <= 1'b1;
      end
    end

    assign word[g*8 +: 8] = lane_byte;
    assign be[g]          = lane_en;

    // a lane is written at most once between flushes
    assert_no_lane_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> !lane_en);
  end

  assert_take_clr_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && clr));

endmodule

// File: rtl/dma_in_irq.sv
module dma_in_irq #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] ack,
  input  logic [W-1:0] mask,
  output logic [W-1:0] raw,
  output logic         irq
);

  logic [W-1:0] raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~ack) | set;
  end

  assign raw = raw_q;
  assign irq = |(raw_q & mask);

  assert_raw_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack == '0) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  assert_set_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((raw_q & $past(set)) == $past(set)));

endmodule

// File: rtl/dma_in_engine.sv
module dma_in_engine
  import dma_in_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   start_desc,
  input  logic [AW-1:0]   ctx_addr,
  input  logic [7:0]      in_data,
  input  logic            in_valid,
  input  logic            in_eop,
  output logic            in_ready,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_be,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  input  logic [3:0]      intr_mask,
  input  logic [3:0]      intr_ack,
  output logic [3:0]      irq_raw,
  output logic            irq,
  output logic            halted
);

  localparam int NB = DW / 8;
  localparam int LW = $clog2(NB);

  // ---------------- arithmetic helpers
  function automatic logic [LW-1:0] lane_of(input logic [AW-1:0] a);
    return a[LW-1:0];
  endfunction

  function automatic logic [AW-1:0] word_base(input logic [AW-1:0] a);
    return {a[AW-1:LW], {LW{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] field_addr(input logic [AW-1:0] d, input logic [1:0] idx);
    return d + (AW'(idx) << LW);
  endfunction

  function automatic logic word_closes(input logic [AW-1:0] nxt, input logic [AW-1:0] endp,
                                       input logic eop);
    return (lane_of(nxt) == '0) || (nxt == endp) || eop;
  endfunction

  // ---------------- state
  eng_state_e    state_q;
  logic [AW-1:0] desc_q;
  logic [AW-1:0] link_q;
  logic [DW-1:0] flags_q;
  logic [AW-1:0] end_q;
  logic [AW-1:0] ptr_q;
  logic [1:0]    idx_q;
  logic          pkt_end_q;

  // ---------------- named events
  logic          take_byte;
  logic          mem_done;
  logic          flush_done;
  logic          desc_retire;
  logic [AW-1:0] ptr_next;
  logic [AW-1:0] rd_addr;
  logic [RAW_W-1:0] raw_set;
  logic [DW-1:0] pk_word;
  logic [NB-1:0] pk_be;

  assign in_ready    = (state_q == ST_RUN);
  assign halted      = (state_q == ST_HALT);
  assign take_byte   = in_ready && in_valid;
  assign mem_done    = mem_req && mem_ack;
  assign flush_done  = (state_q == ST_FLUSH) && mem_ack;
  assign desc_retire = (state_q == ST_WB_FLAGS) && mem_ack;
  assign ptr_next    = ptr_q + AW'(1);
  assign rd_addr     = AW'(mem_rdata);

  always_comb begin
    raw_set = '0;
    if (desc_retire) begin
      raw_set[RAW_DONE_A] = flags_q[FLAG_IRQ];
      raw_set[RAW_DONE_B] = flags_q[FLAG_IRQ];
      raw_set[RAW_PKT]    = pkt_end_q;
    end
  end

  // ---------------- memory master
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = '0;
    unique case (state_q)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = field_addr(desc_q, idx_q);
        mem_be   = '1;
      end
      ST_FLUSH: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = word_base(ptr_q - AW'(1));
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      ST_WB_END: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = field_addr(desc_q, 2'(W_END));
        mem_wdata = DW'(ptr_q);
        mem_be    = '1;
      end
      ST_WB_FLAGS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = field_addr(desc_q, 2'(W_FLAGS));
        mem_wdata = flags_q | (DW'(pkt_end_q) << FLAG_PKT_END);
        mem_be    = '1;
      end
      ST_WB_CTX: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = word_base(ctx_addr);
        mem_wdata = DW'(1) << CTX_OFF_BIT;
        mem_be    = NB'(1) << (CTX_OFF_BIT / 8);
      end
      default: ;
    endcase
  end

  // ---------------- sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      desc_q    <= '0;
      link_q    <= '0;
      flags_q   <= '0;
      end_q     <= '0;
      ptr_q     <= '0;
      idx_q     <= '0;
      pkt_end_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_HALT: begin
          if (start) begin
            desc_q  <= start_desc;
            idx_q   <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            unique case (idx_q)
              2'(W_LINK):  link_q  <= rd_addr;
              2'(W_START): ptr_q   <= rd_addr;
              2'(W_FLAGS): flags_q <= mem_rdata;
              default:     end_q   <= rd_addr;
            endcase
            idx_q <= idx_q + 2'd1;
            if (idx_q == 2'(W_END)) begin
              pkt_end_q <= 1'b0;
              state_q   <= (ptr_q == rd_addr) ? ST_WB_END : ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (in_valid) begin
            ptr_q     <= ptr_next;
            pkt_end_q <= in_eop;
            if (word_closes(ptr_next, end_q, in_eop)) state_q <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          if (mem_ack) state_q <= (ptr_q == end_q || pkt_end_q) ? ST_WB_END : ST_RUN;
        end
        ST_WB_END: begin
          if (mem_ack) state_q <= ST_WB_FLAGS;
        end
        ST_WB_FLAGS: begin
          if (mem_ack) begin
            if (flags_q[FLAG_LAST]) begin
              state_q <= ST_WB_CTX;
            end else begin
              desc_q  <= link_q;
              idx_q   <= '0;
              state_q <= ST_FETCH;
            end
          end
        end
        default: begin
          if (mem_ack) state_q <= ST_HALT;
        end
      endcase
    end
  end

  // ---------------- sub-blocks
  dma_in_packer #(.DW(DW)) u_packer (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take_byte),
    .lane  (lane_of(ptr_q)),
    .din   (in_data),
    .clr   (flush_done),
    .word  (pk_word),
    .be    (pk_be)
  );

  dma_in_irq #(.W(RAW_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (raw_set),
    .ack   (intr_ack),
    .mask  (intr_mask),
    .raw   (irq_raw),
    .irq   (irq)
  );

  // ---------------- assertions
  assert_ptr_below_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (ptr_q < end_q));

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)
                              && $stable(mem_be) && $stable(mem_we)));

  assert_ready_excl_mem_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!in_ready && !mem_req));

  assert_write_has_lanes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != '0));

  assert_retire_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_done && (state_q == ST_WB_END) |-> ((ptr_q == end_q) || pkt_end_q));

endmodule

// File: tb/dma_in_engine_bench.sv
module dma_in_engine_bench;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [31:0] CTX = 32'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_desc = '0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_eop = 1'b0;
  logic in_ready;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [3:0] mem_be;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic [3:0] intr_mask = '0;
  logic [3:0] intr_ack = '0;
  logic [3:0] irq_raw;
  logic irq, halted;

  always #5 clk = ~clk;

  dma_in_engine #(.AW(AW), .DW(DW)) u_dma_in_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_desc(start_desc), .ctx_addr(CTX),
    .in_data(in_data), .in_valid(in_valid), .in_eop(in_eop), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .intr_mask(intr_mask), .intr_ack(intr_ack), .irq_raw(irq_raw), .irq(irq), .halted(halted)
  );

  logic [7:0] mem     [0:1023];
  logic [7:0] exp_mem [0:1023];
  int vectors = 0;
  int fails = 0;
  bit done = 0;
  bit overlap = 0;

  int d_buf [4];
  int d_end [4];
  logic [31:0] d_flag [4];
  int n_desc;
  bit eop_plan [256];
  int m_idx, m_ptr;
  bit m_halted;
  logic [3:0] m_raw = '0;

  // memory model: random acknowledge, same-cycle read data
  always @(negedge clk) begin
    int a;
    a = int'(mem_addr[9:0]);
    if (mem_req && in_ready) overlap = 1;
    if (mem_req && ($urandom_range(0, 3) != 0)) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        for (int k = 0; k < 4; k++) if (mem_be[k]) mem[a+k] = mem_wdata[8*k +: 8];
      end else begin
        mem_rdata = {mem[a+3], mem[a+2], mem[a+1], mem[a]};
      end
    end else begin
      mem_ack   = 1'b0;
      mem_rdata = '0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mem_word(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  function automatic logic [31:0] exp_word(input int a);
    return {exp_mem[a+3], exp_mem[a+2], exp_mem[a+1], exp_mem[a]};
  endfunction

  task automatic put_exp(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) exp_mem[a+k] = v[8*k +: 8];
  endtask

  task automatic put_both(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) begin
      exp_mem[a+k] = v[8*k +: 8];
      mem[a+k]     = v[8*k +: 8];
    end
  endtask

  // reference: retire the current descriptor
  task automatic m_finish(input bit e);
    put_exp(16*m_idx + 12, 32'(m_ptr));
    put_exp(16*m_idx + 8, d_flag[m_idx] | (32'(e) << 11));
    if (d_flag[m_idx][4]) m_raw |= 4'b0011;
    if (e) m_raw |= 4'b1000;
    if (d_flag[m_idx][0]) begin
      exp_mem[CTX + 1] = 8'h80;
      m_halted = 1;
    end else begin
      m_idx++;
      m_ptr = d_buf[m_idx];
    end
  endtask

  task automatic m_settle;
    while (!m_halted && m_ptr == d_end[m_idx]) m_finish(1'b0);
  endtask

  task automatic m_accept(input logic [7:0] b, input bit e);
    exp_mem[m_ptr] = b;
    m_ptr++;
    if (m_ptr == d_end[m_idx] || e) m_finish(e);
    m_settle();
  endtask

  task automatic build_mem;
    for (int a = 0; a < 1024; a++) begin
      mem[a]     = 8'($urandom);
      exp_mem[a] = mem[a];
    end
    for (int i = 0; i < n_desc; i++) begin
      put_both(16*i + 0, 32'(16*(i+1)));
      put_both(16*i + 4, 32'(d_buf[i]));
      put_both(16*i + 8, d_flag[i]);
      put_both(16*i + 12, 32'(d_end[i]));
    end
  endtask

  task automatic run_round;
    bit pending;
    int k;
    int bad;
    logic [3:0] mk;
    build_mem();
    m_idx = 0;
    m_ptr = d_buf[0];
    m_halted = 0;
    overlap = 0;
    m_settle();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pending = 0;
    k = 0;
    while (!m_halted) begin
      if (!pending) begin
        if ($urandom_range(0, 9) < 7) begin
          in_valid = 1'b1;
          in_data  = 8'($urandom);
          in_eop   = eop_plan[k];
          pending  = 1;
        end else begin
          in_valid = 1'b0;
        end
      end
      if (pending && in_ready) begin
        m_accept(in_data, in_eop);
        k++;
        pending = 0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_eop   = 1'b0;
    while (!halted) @(negedge clk);
    // memory image: buffers R1, descriptor end R4, flags R5, context R8, rest R10
    for (int a = 0; a < 1024; a += 4) begin
      if (a >= 32'h100)            check(mem_word(a) == exp_word(a), "R1 buffer data", mem_word(a), exp_word(a));
      else if (a == 32'(CTX))      check(mem_word(a) == exp_word(a), "R8 context word", mem_word(a), exp_word(a));
      else if (a < 64 && a % 16 == 12) check(mem_word(a) == exp_word(a), "R4 end writeback", mem_word(a), exp_word(a));
      else if (a < 64 && a % 16 == 8)  check(mem_word(a) == exp_word(a), "R5 flags writeback", mem_word(a), exp_word(a));
      else                         check(mem_word(a) == exp_word(a), "R10 untouched word", mem_word(a), exp_word(a));
    end
    check(overlap == 0, "R11 ready during memory access", 32'(overlap), 0);
    check(irq_raw == m_raw, "R6 raw interrupts", 32'(irq_raw), 32'(m_raw));
    for (int j = 0; j < 3; j++) begin
      mk = (j == 0) ? 4'h0 : (j == 1) ? 4'h8 : 4'($urandom);
      intr_mask = mk;
      #1;
      check(irq == |(m_raw & mk), "R7 masked line", 32'(irq), 32'(|(m_raw & mk)));
    end
    intr_mask = '0;
    // halted engine refuses input
    in_valid = 1'b1;
    in_data  = 8'hA5;
    bad = 0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (in_ready || !halted) bad++;
    end
    in_valid = 1'b0;
    check(bad == 0, "R8 input refused while halted", 32'(bad), 0);
    bad = 0;
    for (int a = 0; a < 1024; a++) if (mem[a] != exp_mem[a]) bad++;
    check(bad == 0, "R8 memory unchanged while halted", 32'(bad), 0);
    intr_ack = 4'hF;
    @(negedge clk);
    intr_ack = 4'h0;
    check(irq_raw == 4'h0, "R6 acknowledge clears", 32'(irq_raw), 0);
    m_raw = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < 1024; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(in_ready == 0, "R12 reset in_ready", 32'(in_ready), 0);
    check(mem_req == 0, "R12 reset mem_req", 32'(mem_req), 0);
    check(irq_raw == 0, "R12 reset irq_raw", 32'(irq_raw), 0);
    check(irq == 0, "R12 reset irq", 32'(irq), 0);
    check(halted == 0, "R12 reset halted", 32'(halted), 0);
    @(negedge clk);

    // directed A: full fill, early packet end, packet end on last byte
    n_desc = 3;
    d_buf[0] = 32'h101; d_end[0] = 32'h108; d_flag[0] = 32'h0000_0010;
    d_buf[1] = 32'h142; d_end[1] = 32'h14C; d_flag[1] = 32'h0000_2000;
    d_buf[2] = 32'h183; d_end[2] = 32'h188; d_flag[2] = 32'h0000_0011;
    for (int i = 0; i < 256; i++) eop_plan[i] = 0;
    eop_plan[9]  = 1;
    eop_plan[14] = 1;
    run_round();
    check(mem_word(28) == 32'h145, "R3 truncated end", mem_word(28), 32'h145);
    check(mem_word(24) == 32'h2800, "R3 packet-end flag", mem_word(24), 32'h2800);
    check(mem[32'h142] == exp_mem[32'h142], "R9 next buffer start", 32'(mem[32'h142]), 32'(exp_mem[32'h142]));
    check(mem[32'h14C] == exp_mem[32'h14C] && mem[32'h145] == exp_mem[32'h145],
          "R1 no write past end", 32'(mem[32'h145]), 32'(exp_mem[32'h145]));

    // directed B: empty descriptors around a short aligned one
    n_desc = 3;
    d_buf[0] = 32'h100; d_end[0] = 32'h100; d_flag[0] = 32'h0000_0010;
    d_buf[1] = 32'h140; d_end[1] = 32'h143; d_flag[1] = 32'h0000_0000;
    d_buf[2] = 32'h180; d_end[2] = 32'h180; d_flag[2] = 32'h0000_0001;
    for (int i = 0; i < 256; i++) eop_plan[i] = 0;
    run_round();
    check(mem_word(12) == 32'h100, "R2 empty descriptor end", mem_word(12), 32'h100);
    check(mem_word(44) == 32'h180, "R2 empty last descriptor", mem_word(44), 32'h180);
    check(mem_word(28) == 32'h143, "R9 chain followed", mem_word(28), 32'h143);

    // random chains
    for (int r = 0; r < 24; r++) begin
      int len;
      n_desc = $urandom_range(1, 4);
      for (int i = 0; i < n_desc; i++) begin
        len = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1, 40);
        d_buf[i] = 32'h100 + 32'h40 * i + $urandom_range(0, 3);
        d_end[i] = d_buf[i] + len;
        d_flag[i] = ($urandom & 32'hFFFF_F7EE) | (32'($urandom_range(0, 1)) << 4)
                  | ((i == n_desc - 1) ? 32'h1 : 32'h0);
      end
      for (int i = 0; i < 256; i++) eop_plan[i] = ($urandom_range(0, 5) == 0);
      run_round();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule